// File: doc/BRIEF.md
# Three-Channel Interval Timer

This peripheral holds three independent up-counters behind one word-addressed register bus. Each channel can divide its count source by a power of two, take that source either from the system clock or from a per-channel external tick enable, and run either free (wrapping from all-ones to zero) or in interval mode, where it wraps to zero after reaching a programmed limit. Events are latched in a per-channel status register that clears when read, and a per-channel interrupt line rises when a latched event is also enabled.

Software programs a channel by writing its clock-control, counter-control, interval and enable registers, then polls the counter value or waits for the interrupt and reads the status register to acknowledge it. Read data is registered: it appears on the bus one clock after the read strobe.

Top module: `trio_tmr`

## Requirements
- R1: Byte addresses select a register group and channel: clock control at 0x00, counter control at 0x0C, counter value at 0x18, interval at 0x24, status at 0x54, enable at 0x60, with channel c at group + 4*c; reads of any other address return 0; read data is valid the cycle after the read strobe.
- R2: After reset every channel reads clock control 0, counter control 0x01 (stopped), counter value 0, interval 0, status 0, enable 0, and all interrupt lines are low.
- R3: With clock-control bit 0 set and prescale field N in bits 4:1, the counter advances once every 2^(N+1) source ticks; with bit 0 clear it advances on every source tick.
- R4: Clock-control bit 5 set makes the external tick input of that channel the source tick; with it clear every clock is a source tick.
- R5: Counter-control bit 0 set holds the counter; clearing it resumes counting from the held value.
- R6: Writing counter-control bit 4 as 1 zeroes the counter and the prescaler phase at that write; the bit always reads back 0.
- R7: With counter-control bit 1 set, an advance from a count equal to the interval register gives 0 and sets status bit 0.
- R8: With counter-control bit 1 clear, the counter rolls from all-ones to zero and that advance sets status bit 4.
- R9: A status read returns the flags and clears them in the same access, except a flag raised in that same cycle, which stays set.
- R10: A channel's interrupt is high exactly when some status bit and the matching enable bit are both set; a zero enable still lets status record events.
- R11: Counter-control bit 5 is stored and read back but does not change counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_tick | input | 3 | Per-channel external count enable |
| irq | output | 3 | Per-channel interrupt |

## Verification
A wrong prescaler phase or limit shows as a counter value off by whole divisions in the first read after a run of known length, so sweeps of run length against each prescale setting catch it within a few divide periods. A bad interval compare or rollover shows immediately as a wrong residue of the run length and a missing or extra status flag on the next status read. Lost or sticky status flags show on the second of two back-to-back status reads, and masking faults show on the interrupt line in the cycle after the enable write.

// File: rtl/trio_tmr_pkg.sv
package trio_tmr_pkg;
  localparam int NCH   = 3;
  localparam int CTL_W = 6;
  localparam int ST_W  = 5;
  localparam int SEL_W = 4;

  // Word index of channel 0 in each register group
  localparam int WI_CLK = 0;
  localparam int WI_CNT = 3;
  localparam int WI_VAL = 6;
  localparam int WI_IVL = 9;
  localparam int WI_ST  = 21;
  localparam int WI_EN  = 24;

  // Field positions
  localparam int CK_PRE_EN = 0;
  localparam int CK_SRC    = 5;
  localparam int CC_HOLD   = 0;
  localparam int CC_IVL    = 1;
  localparam int CC_ZERO   = 4;
  localparam int ST_MATCH  = 0;
  localparam int ST_WRAP   = 4;

  localparam logic [CTL_W-1:0] CC_RESET = 6'h01;
endpackage

// File: rtl/trio_tmr_presc.sv
module trio_tmr_presc #(
  parameter int SEL_W = 4,
  localparam int DIV_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             adv
);
  logic [DIV_W-1:0] div_q, div_n, lim;
  logic [SEL_W:0]   shamt;
  logic             hit;

  always_comb begin
    shamt = {1'b0, sel} + 1'b1;
    lim   = ~({DIV_W{1'b1}} << shamt);
    hit   = (div_q >= lim);
    adv   = step & (~en | hit);
  end

  always_comb begin
    div_n = div_q;
    if (clr)
      div_n = '0;
    else if (step && en)
      div_n = hit ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end

  // R3: without a source tick the prescaler phase cannot move
  a_r3_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(div_q));
endmodule

// File: rtl/trio_tmr_chan.sv
module trio_tmr_chan
  import trio_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_tick,
  input  logic             wr_clk,
  input  logic             wr_cnt,
  input  logic             wr_ivl,
  input  logic             wr_en,
  input  logic             rd_st,
  input  logic [CNT_W-1:0] wdat,
  output logic [CTL_W-1:0] clk_ctl_o,
  output logic [CTL_W-1:0] cnt_ctl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ivl_o,
  output logic [ST_W-1:0]  st_o,
  output logic [ST_W-1:0]  en_o,
  output logic             irq_o
);
  logic [CTL_W-1:0] clk_ctl_q, clk_ctl_n;
  logic [CTL_W-1:0] cnt_ctl_q, cnt_ctl_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] ivl_q, ivl_n;
  logic [ST_W-1:0]  st_q, st_n, st_set;
  logic [ST_W-1:0]  en_q, en_n;
  logic             zero_req, run, ivl_mode, src_tick, adv, at_lim;

  assign zero_req = wr_cnt & wdat[CC_ZERO];
  assign run      = ~cnt_ctl_q[CC_HOLD];
  assign ivl_mode = cnt_ctl_q[CC_IVL];
  assign src_tick = clk_ctl_q[CK_SRC] ? ext_tick : 1'b1;
  assign at_lim   = (cnt_q == ivl_q);

  trio_tmr_presc #(.SEL_W(SEL_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (zero_req),
    .step (run & src_tick),
    .en   (clk_ctl_q[CK_PRE_EN]),
    .sel  (clk_ctl_q[SEL_W:1]),
    .adv  (adv)
  );

  // Configuration registers
  always_comb begin
    clk_ctl_n = wr_clk ? wdat[CTL_W-1:0] : clk_ctl_q;
    cnt_ctl_n = cnt_ctl_q;
    if (wr_cnt) begin
      cnt_ctl_n          = wdat[CTL_W-1:0];
      cnt_ctl_n[CC_ZERO] = 1'b0;
    end
    ivl_n = wr_ivl ? wdat : ivl_q;
    en_n  = wr_en  ? wdat[ST_W-1:0] : en_q;
  end

  // Counter and event detection
  always_comb begin
    st_set = '0;
    cnt_n  = cnt_q;
    if (zero_req) begin
      cnt_n = '0;
    end else if (adv) begin
      if (ivl_mode) begin
        cnt_n            = at_lim ? '0 : cnt_q + 1'b1;
        st_set[ST_MATCH] = at_lim;
      end else begin
        cnt_n           = cnt_q + 1'b1;
        st_set[ST_WRAP] = &cnt_q;
      end
    end
    st_n = (rd_st ? '0 : st_q) | st_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_ctl_q <= '0;
      cnt_ctl_q <= CC_RESET;
      cnt_q     <= '0;
      ivl_q     <= '0;
      st_q      <= '0;
      en_q      <= '0;
    end else begin
      clk_ctl_q <= clk_ctl_n;
      cnt_ctl_q <= cnt_ctl_n;
      cnt_q     <= cnt_n;
      ivl_q     <= ivl_n;
      st_q      <= st_n;
      en_q      <= en_n;
    end
  end

  assign clk_ctl_o = clk_ctl_q;
  assign cnt_ctl_o = cnt_ctl_q;
  assign cnt_o     = cnt_q;
  assign ivl_o     = ivl_q;
  assign st_o      = st_q;
  assign en_o      = en_q;
  assign irq_o     = |(st_q & en_q);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !zero_req) |=> $stable(cnt_q));
  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (cnt_q == '0));
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ivl_mode && at_lim && !zero_req) |=> (cnt_q == '0 && st_q[ST_MATCH]));
  a_r8_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ivl_mode && (&cnt_q) && !zero_req) |=> st_q[ST_WRAP]);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_MATCH] && !rd_st) |=> st_q[ST_MATCH]);
endmodule

// File: rtl/trio_tmr.sv
module trio_tmr
  import trio_tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    ext_tick,
  output logic [NCH-1:0]    irq
);
  localparam int WI_W = ADDR_W - 2;

  logic [WI_W-1:0] widx;
  logic [NCH-1:0]  wr_clk, wr_cnt, wr_ivl, wr_en, rd_st;
  logic [CTL_W-1:0] clk_ctl [NCH];
  logic [CTL_W-1:0] cnt_ctl [NCH];
  logic [CNT_W-1:0] cnt     [NCH];
  logic [CNT_W-1:0] ivl     [NCH];
  logic [ST_W-1:0]  st      [NCH];
  logic [ST_W-1:0]  en      [NCH];
  logic [31:0]      rmux, rdata_q, rdata_n;
  logic             unused_bits;

  assign widx        = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:CNT_W]};

  always_comb begin
    wr_clk = '0; wr_cnt = '0; wr_ivl = '0; wr_en = '0; rd_st = '0;
    rmux   = '0;
    for (int c = 0; c < NCH; c++) begin
      if (widx == WI_W'(WI_CLK + c)) begin
        wr_clk[c] = bus_wr;
        rmux      = 32'(clk_ctl[c]);
      end
      if (widx == WI_W'(WI_CNT + c)) begin
        wr_cnt[c] = bus_wr;
        rmux      = 32'(cnt_ctl[c]);
      end
      if (widx == WI_W'(WI_VAL + c))
        rmux = 32'(cnt[c]);
      if (widx == WI_W'(WI_IVL + c)) begin
        wr_ivl[c] = bus_wr;
        rmux      = 32'(ivl[c]);
      end
      if (widx == WI_W'(WI_ST + c)) begin
        rd_st[c] = bus_rd;
        rmux     = 32'(st[c]);
      end
      if (widx == WI_W'(WI_EN + c)) begin
        wr_en[c] = bus_wr;
        rmux     = 32'(en[c]);
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    trio_tmr_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_tick (ext_tick[c]),
      .wr_clk   (wr_clk[c]),
      .wr_cnt   (wr_cnt[c]),
      .wr_ivl   (wr_ivl[c]),
      .wr_en    (wr_en[c]),
      .rd_st    (rd_st[c]),
      .wdat     (bus_wdata[CNT_W-1:0]),
      .clk_ctl_o(clk_ctl[c]),
      .cnt_ctl_o(cnt_ctl[c]),
      .cnt_o    (cnt[c]),
      .ivl_o    (ivl[c]),
      .st_o     (st[c]),
      .en_o     (en[c]),
      .irq_o    (irq[c])
    );
  end

  assign rdata_n = bus_rd ? rmux : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;

  // R1: read data only changes on a read access
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R6: the zeroing bit never reads back as set
  a_r6_zero_reads_0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && widx >= WI_W'(WI_CNT) && widx < WI_W'(WI_CNT + NCH)) |=> !bus_rdata[CC_ZERO]);
endmodule

// File: tb/sim_trio_tmr.sv
module sim_trio_tmr;
  localparam int CW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  ext_tick = '0;
  logic [2:0]  irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trio_tmr #(.CNT_W(CW), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .irq(irq)
  );

  localparam logic [7:0] A_CK = 8'h00, A_CC = 8'h0C, A_VAL = 8'h18,
                         A_IV = 8'h24, A_ST = 8'h54, A_EN = 8'h60;

  function automatic logic [7:0] ad(input logic [7:0] g, input int c);
    return g + 8'(4 * c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge; each access spans one rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int m);
    repeat (m) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state, R1 unmapped address
    for (int c = 0; c < 3; c++) begin
      rd(ad(A_CK, c), v);  check("R2 clk ctl", v, 0);
      rd(ad(A_CC, c), v);  check("R2 cnt ctl", v, 32'h01);
      rd(ad(A_VAL, c), v); check("R2 value", v, 0);
      rd(ad(A_IV, c), v);  check("R2 interval", v, 0);
      rd(ad(A_ST, c), v);  check("R2 status", v, 0);
      rd(ad(A_EN, c), v);  check("R2 enable", v, 0);
    end
    check("R2 irq", 32'(irq), 0);
    rd(8'h30, v); check("R1 unmapped", v, 0);

    // R3 no prescale, R6 zeroing, R1 channel 0 map: T edges counted
    for (int t = 1; t <= 6; t++) begin
      wr(ad(A_CC, 0), 32'h10);
      idle(t - 1);
      wr(ad(A_CC, 0), 32'h01);
      rd(ad(A_VAL, 0), v); check("R3 undivided count", v, 32'(t));
    end

    // R5 hold then resume from held value (held value 6)
    idle(4);
    rd(ad(A_VAL, 0), v); check("R5 held", v, 6);
    wr(ad(A_CC, 0), 32'h00);
    idle(2);
    wr(ad(A_CC, 0), 32'h01);
    rd(ad(A_VAL, 0), v); check("R5 resumed", v, 9);

    // R3 prescale sweep: count = T >> (N+1)
    for (int n = 0; n < 4; n++) begin
      wr(ad(A_CK, 0), 32'(1 | (n << 1)));
      for (int t = 1; t <= 20; t += 3) begin
        wr(ad(A_CC, 0), 32'h10);
        idle(t - 1);
        wr(ad(A_CC, 0), 32'h01);
        rd(ad(A_VAL, 0), v); check("R3 prescaled count", v, 32'(t >> (n + 1)));
      end
    end
    wr(ad(A_CK, 0), 32'(1 | (10 << 1)));
    wr(ad(A_CC, 0), 32'h10);
    idle(3 * 2048 + 4);
    wr(ad(A_CC, 0), 32'h01);
    rd(ad(A_VAL, 0), v); check("R3 divide by 2048", v, 3);

    // R4 external source, undivided then divided by 2
    wr(ad(A_CK, 0), 32'h20);
    wr(ad(A_CC, 0), 32'h10);
    idle(4);
    ext_tick[0] = 1'b1; idle(3); ext_tick[0] = 1'b0;
    idle(2);
    wr(ad(A_CC, 0), 32'h01);
    rd(ad(A_VAL, 0), v); check("R4 ext ticks", v, 3);
    wr(ad(A_CK, 0), 32'h21);
    wr(ad(A_CC, 0), 32'h10);
    ext_tick[0] = 1'b1; idle(5); ext_tick[0] = 1'b0;
    wr(ad(A_CC, 0), 32'h01);
    rd(ad(A_VAL, 0), v); check("R4 ext ticks divided", v, 2);

    // R6 readback, R11 stored bit 5 without effect
    wr(ad(A_CK, 0), 32'h00);
    wr(ad(A_CC, 0), 32'h31);
    rd(ad(A_CC, 0), v); check("R6 zero bit reads 0 / R11 stored", v, 32'h21);
    rd(ad(A_VAL, 0), v); check("R6 zeroed", v, 0);
    wr(ad(A_CC, 0), 32'h30);
    idle(3);
    wr(ad(A_CC, 0), 32'h21);
    rd(ad(A_VAL, 0), v); check("R11 counts unchanged", v, 4);

    // R7 interval mode on channel 1, limit 4: count = T mod 5
    wr(ad(A_IV, 1), 32'd4);
    for (int t = 1; t <= 12; t++) begin
      wr(ad(A_CC, 1), 32'h12);
      idle(t - 1);
      wr(ad(A_CC, 1), 32'h03);
      rd(ad(A_VAL, 1), v); check("R7 interval count", v, 32'(t % 5));
      rd(ad(A_ST, 1), v);  check("R7 match flag", v, (t >= 5) ? 32'h01 : 32'h00);
      rd(ad(A_ST, 1), v);  check("R9 cleared by read", v, 0);
    end

    // R10 masking and enable
    wr(ad(A_CC, 1), 32'h12);
    idle(4);
    wr(ad(A_CC, 1), 32'h03);
    check("R10 masked irq", 32'(irq), 0);
    wr(ad(A_EN, 1), 32'h01);
    check("R10 enabled irq", 32'(irq), 32'h2);
    rd(ad(A_ST, 1), v); check("R10 status", v, 32'h01);
    check("R10 irq drops after read", 32'(irq), 0);

    // R8 free-running rollover on channel 2
    wr(ad(A_EN, 2), 32'h10);
    wr(ad(A_CC, 2), 32'h10);
    idle((1 << CW) + 2);
    wr(ad(A_CC, 2), 32'h01);
    rd(ad(A_VAL, 2), v); check("R8 wrapped count", v, 3);
    check("R8 irq on wrap", 32'(irq), 32'h4);
    rd(ad(A_ST, 2), v); check("R8 wrap flag", v, 32'h10);
    check("R8 irq cleared", 32'(irq), 0);

    // R9 set in the same cycle as the clearing read
    wr(ad(A_IV, 2), 32'd0);
    wr(ad(A_CC, 2), 32'h12);
    idle(2);
    rd(ad(A_ST, 2), v); check("R9 flag seen", v, 32'h01);
    rd(ad(A_ST, 2), v); check("R9 flag kept on collision", v, 32'h01);
    check("R10 match not enabled on ch2", 32'(irq), 0);
    wr(ad(A_CC, 2), 32'h03);
    rd(ad(A_ST, 2), v); check("R9 last event", v, 32'h01);
    rd(ad(A_ST, 2), v); check("R9 finally clear", v, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule